// File: doc/BRIEF.md
# Transceiver Core Bring-Up Sequencer

A small hardware bus master that stands in for a processor during start-up of a multi-channel serial transceiver core. Once the core reports ready, it plays a fixed script of register writes over a single-beat valid/ready write port. The script unlocks the configuration space with a two-write key. It then takes every channel's outputs out of high impedance and forces the line alarm on every channel. After that it waits a set number of frames, pulses the alignment-FIFO resync bit, waits the same number of frames again, and releases the alarms.

Frames are counted from a frame-pulse input. When the last write has been accepted, a done flag rises and holds until the next reset. A synchronous active-low reset returns the block to idle at any point in the script.

Top module: `core_bringup_seq`

## Requirements
- R1: While rst_n is low at a clock edge, wr_valid and done are low after that edge.
- R2: After reset, no write is issued until core_ready is seen high at a clock edge. The first write is presented in the cycle after that edge.
- R3: The first two writes unlock the core: data 0xA0 to address 0x04, then data 0x01 to address 0x05.
- R4: The next four writes enable the channel outputs by writing data 0x01 (bit 0 = output enable) to addresses 0x20, 0x38, 0x50 and 0x68, in that order.
- R5: The next four writes force the line alarm by writing data 0x03 (bit 0 = enable, bit 1 = alarm force) to the same four addresses, in the same order.
- R6: After the last alarm write, the block waits for four frames and then writes data 0x02 (bit 1 = resync) to address 0x06.
- R7: After the resync write, the block waits for four more frames. It then writes data 0x01 to the four channel addresses in order, which keeps the enable set and clears the alarm force.
- R8: A write holds wr_valid, wr_addr and wr_data steady until wr_ready is high. A transfer completes at a clock edge where wr_valid and wr_ready are both high, and the next write may be presented in the following cycle.
- R9: One frame is a rising edge of frame_pulse, so a pulse held high for several cycles counts once. Rising edges seen outside a wait state are not counted.
- R10: After the last release write is accepted, done goes high and stays high, and wr_valid stays low.
- R11: Asserting reset in the middle of the script returns the block to idle. The script then restarts from the first unlock write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_ready | input | 1 | Core ready to accept configuration |
| frame_pulse | input | 1 | Frame marker; each rising edge is one frame |
| wr_valid | output | 1 | Write request present |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| wr_ready | input | 1 | Target accepts the presented write |
| done | output | 1 | Script complete (sticky until reset) |

## Verification
The hardest case is a frame edge that arrives while a write is stalled by a low wr_ready, or a pulse that is wider than one cycle and straddles the entry into a wait state. Only a correct design leaves such an edge uncounted. The stimulus reaches these cases with a pseudo-random wr_ready pattern against short frame periods, and with a separate run that uses three-cycle pulses. A behavioural model of the wait rules is compared with the outputs on every clock. A reset dropped into the middle of a randomly stalled run checks the restart.

// File: rtl/bringup_pkg.sv
// Shared types and script constants for the bring-up sequencer.
// Assumes 8-bit addresses and data on the core's write port.
package bringup_pkg;
    localparam int AW = 8;
    localparam int DW = 8;

    localparam logic [AW-1:0] UNLOCK_ADDR_A = 8'h04;
    localparam logic [DW-1:0] UNLOCK_KEY_A  = 8'hA0;
    localparam logic [AW-1:0] UNLOCK_ADDR_B = 8'h05;
    localparam logic [DW-1:0] UNLOCK_KEY_B  = 8'h01;
    localparam logic [AW-1:0] RESYNC_ADDR   = 8'h06;
    localparam logic [DW-1:0] RESYNC_BIT    = 8'h02;
    localparam logic [DW-1:0] CH_OUT_EN     = 8'h01;
    localparam logic [DW-1:0] CH_ALARM_SET  = 8'h02;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          wait_after;
    } step_t;
endpackage

// File: rtl/bringup_script.sv
// Combinational script store: maps a step index to the write it performs
// and whether a frame wait follows it. Assumes idx < 3 + 3*NUM_CH.
module bringup_script
    import bringup_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int CH_BASE   = 32'h20,
    parameter int CH_STRIDE = 32'h18,
    parameter int IDX_W     = 4
) (
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);
    localparam int EN_END    = 2 + NUM_CH;
    localparam int ALARM_END = 2 + 2 * NUM_CH;

    // Decode the step index into address, data and wait flag.
    always_comb begin
        int i;
        int ch;
        i    = int'(idx);
        ch   = 0;
        step = '0;
        if (i == 0) begin
            step.addr = UNLOCK_ADDR_A;
            step.data = UNLOCK_KEY_A;
        end else if (i == 1) begin
            step.addr = UNLOCK_ADDR_B;
            step.data = UNLOCK_KEY_B;
        end else if (i < EN_END) begin
            ch        = i - 2;
            step.addr = AW'(CH_BASE + ch * CH_STRIDE);
            step.data = CH_OUT_EN;
        end else if (i < ALARM_END) begin
            ch              = i - EN_END;
            step.addr       = AW'(CH_BASE + ch * CH_STRIDE);
            step.data       = CH_OUT_EN | CH_ALARM_SET;
            step.wait_after = (ch == NUM_CH - 1);
        end else if (i == ALARM_END) begin
            step.addr       = RESYNC_ADDR;
            step.data       = RESYNC_BIT;
            step.wait_after = 1'b1;
        end else begin
            ch        = i - ALARM_END - 1;
            step.addr = AW'(CH_BASE + ch * CH_STRIDE);
            step.data = CH_OUT_EN;
        end
    end
endmodule

// File: rtl/bringup_frame_cnt.sv
// Frame counter: counts rising edges of frame_pulse only while in_wait
// is high and flags the edge that completes WAIT_FRAMES frames.
// Assumes in_wait drops in the cycle after reached.
module bringup_frame_cnt #(
    parameter int WAIT_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_pulse,
    input  logic in_wait,
    output logic reached
);
    localparam int CNT_W = $clog2(WAIT_FRAMES + 1);

    logic             fp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;

    assign rise    = frame_pulse & ~fp_q;
    assign reached = in_wait & rise & (cnt_q == CNT_W'(WAIT_FRAMES - 1));

    // Remember the previous frame_pulse level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fp_q <= 1'b0;
        else        fp_q <= frame_pulse;
    end

    // Count edges inside a wait; clear outside it and on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_wait || reached) cnt_q <= '0;
        else if (rise)                     cnt_q <= cnt_q + 1'b1;
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(WAIT_FRAMES));

    // R9
    no_count_outside_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_wait |=> (cnt_q == '0));
endmodule

// File: rtl/core_bringup_seq.sv
// Bring-up sequencer top: after core_ready, steps through the fixed script
// of writes on a valid/ready port, pausing for frame counts where the
// script asks, then raises a sticky done. Synchronous active-low reset.
module core_bringup_seq
    import bringup_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CH_BASE     = 32'h20,
    parameter int CH_STRIDE   = 32'h18,
    parameter int WAIT_FRAMES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_ready,
    input  logic          frame_pulse,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          wr_ready,
    output logic          done
);
    localparam int NUM_STEPS = 3 + 3 * NUM_CH;
    localparam int IDX_W     = $clog2(NUM_STEPS + 1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    step_t            step;
    logic             frames_reached;

    bringup_script #(
        .NUM_CH    (NUM_CH),
        .CH_BASE   (CH_BASE),
        .CH_STRIDE (CH_STRIDE),
        .IDX_W     (IDX_W)
    ) u_script (
        .idx  (idx_q),
        .step (step)
    );

    bringup_frame_cnt #(
        .WAIT_FRAMES (WAIT_FRAMES)
    ) u_frames (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .in_wait     (state_q == ST_WAIT),
        .reached     (frames_reached)
    );

    assign wr_valid = (state_q == ST_WRITE);
    assign wr_addr  = step.addr;
    assign wr_data  = step.data;
    assign done     = (state_q == ST_DONE);

    // Script walker: advance on each accepted write, pause for frame waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE:  if (core_ready) state_q <= ST_WRITE;
                ST_WRITE: if (wr_ready) begin
                    if (idx_q == IDX_W'(NUM_STEPS - 1)) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        if (step.wait_after) state_q <= ST_WAIT;
                    end
                end
                ST_WAIT:  if (frames_reached) state_q <= ST_WRITE;
                default:  state_q <= ST_DONE;
            endcase
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_valid && !done));

    // R2
    wait_core_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !core_ready) |=> !wr_valid);

    // R6
    wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !frames_reached) |=> (state_q == ST_WAIT));

    // R8
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_valid);
endmodule

// File: tb/core_bringup_seq_bench.sv
// Bench: behavioural cycle model compared every clock, plus a log of
// accepted writes checked against the expected script.
module core_bringup_seq_bench;
    localparam int NCH    = 4;
    localparam int NSTEPS = 3 + 3 * NCH;
    localparam int WAIT_A = 1 + 2 * NCH;
    localparam int WAIT_B = 2 + 2 * NCH;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_ready = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       wr_ready = 1'b1;
    logic       wr_valid;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       done;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    int exp_addr [NSTEPS];
    int exp_data [NSTEPS];

    // model state
    int m_phase = 0;
    int m_idx = 0;
    int m_frames = 0;
    bit m_fp_prev = 1'b0;

    // stimulus knobs
    int  fp_period = 20;
    int  fp_width = 1;
    int  fp_cnt = 0;
    bit  rand_ready = 1'b0;
    int  lfsr = 32'h1ACE5;

    // write log
    int log_addr [$];
    int log_data [$];
    int log_gap [$];
    int rises = 0;
    bit fp_seen = 1'b0;

    core_bringup_seq u_core_bringup_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_ready  (core_ready),
        .frame_pulse (frame_pulse),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .done        (done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Build the expected script.
    initial begin
        exp_addr[0] = 'h04; exp_data[0] = 'hA0;
        exp_addr[1] = 'h05; exp_data[1] = 'h01;
        for (int c = 0; c < NCH; c++) begin
            exp_addr[2 + c]           = 'h20 + c * 'h18; exp_data[2 + c]           = 'h01;
            exp_addr[2 + NCH + c]     = 'h20 + c * 'h18; exp_data[2 + NCH + c]     = 'h03;
            exp_addr[3 + 2 * NCH + c] = 'h20 + c * 'h18; exp_data[3 + 2 * NCH + c] = 'h01;
        end
        exp_addr[WAIT_B] = 'h06; exp_data[WAIT_B] = 'h02;
    end

    // Input drivers: frame pulses and ready pattern, changed at negedge.
    always @(negedge clk) begin
        fp_cnt++;
        frame_pulse = (fp_cnt % fp_period) < fp_width;
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hA3000000 : 0);
        wr_ready = rand_ready ? ((lfsr & 3) != 0) : 1'b1;
    end

    // Reference model, advanced at every clock edge.
    always @(posedge clk) begin
        bit rise;
        rise = frame_pulse && !m_fp_prev;
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_frames = 0;
        end else begin
            case (m_phase)
                0: if (core_ready) m_phase = 1;
                1: if (wr_ready) begin
                    if (m_idx == NSTEPS - 1) m_phase = 3;
                    else begin
                        if (m_idx == WAIT_A || m_idx == WAIT_B) begin
                            m_phase = 2; m_frames = 0;
                        end
                        m_idx++;
                    end
                end
                2: if (rise) begin
                    m_frames++;
                    if (m_frames == 4) m_phase = 1;
                end
                default: ;
            endcase
        end
        m_fp_prev = rst_n ? frame_pulse : 1'b0;
    end

    // Per-cycle compare and write logging, away from both edges.
    always begin
        @(negedge clk);
        #2;
        cycles++;
        check(wr_valid === (m_phase == 1), "R8 R9 model valid", wr_valid, m_phase == 1);
        check(done === (m_phase == 3), "R10 model done", done, m_phase == 3);
        if (m_phase == 1) begin
            check(wr_addr == exp_addr[m_idx], "R8 model addr", wr_addr, exp_addr[m_idx]);
            check(wr_data == exp_data[m_idx], "R8 model data", wr_data, exp_data[m_idx]);
        end
        if (rst_n && wr_valid && wr_ready) begin
            log_addr.push_back(wr_addr);
            log_data.push_back(wr_data);
            log_gap.push_back(rises);
            rises = 0;
        end else if (frame_pulse && !fp_seen) begin
            rises++;
        end
        fp_seen = frame_pulse;
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 0);
            finish_run();
        end
    end

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk); #2; n++;
        end
    endtask

    task automatic check_log(input string run);
        check(log_addr.size() == NSTEPS, {"R11 write count ", run}, log_addr.size(), NSTEPS);
        for (int k = 0; k < NSTEPS && k < log_addr.size(); k++) begin
            string tag;
            tag = k < 2 ? "R3" : k < 2 + NCH ? "R4" : k < 2 + 2 * NCH ? "R5" : k == WAIT_B ? "R6" : "R7";
            check(log_addr[k] == exp_addr[k], {tag, " addr ", run}, log_addr[k], exp_addr[k]);
            check(log_data[k] == exp_data[k], {tag, " data ", run}, log_data[k], exp_data[k]);
        end
    endtask

    task automatic clear_log();
        log_addr.delete(); log_data.delete(); log_gap.delete(); rises = 0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #2;
        check(!wr_valid && !done, "R1 reset outputs", {wr_valid, done}, 0);
        @(negedge clk); rst_n = 1'b1;
        // R2: no writes while core_ready low
        repeat (10) @(negedge clk);
        #2;
        check(!wr_valid && log_addr.size() == 0, "R2 idle before ready", wr_valid, 0);
        @(negedge clk); core_ready = 1'b1;
        @(negedge clk); #2;
        check(wr_valid == 1'b1, "R2 first write after ready", wr_valid, 1);
        wait_done();
        check_log("run1");
        if (log_gap.size() == NSTEPS) begin
            check(log_gap[WAIT_B] == 4, "R6 frames before resync", log_gap[WAIT_B], 4);
            check(log_gap[WAIT_B + 1] == 4, "R7 frames before release", log_gap[WAIT_B + 1], 4);
        end
        repeat (30) @(negedge clk);
        #2;
        check(done && !wr_valid, "R10 done sticky", {done, wr_valid}, 2);

        // Run 2: wide pulses count once (R9), reset returns to idle (R11)
        @(negedge clk); rst_n = 1'b0; fp_width = 3; fp_period = 17;
        @(negedge clk); @(negedge clk); #2;
        check(!done && !wr_valid, "R11 reset after done", {done, wr_valid}, 0);
        clear_log();
        @(negedge clk); rst_n = 1'b1;
        wait_done();
        check_log("run2");
        if (log_gap.size() == NSTEPS)
            check(log_gap[WAIT_B] == 4, "R9 wide pulse counted once", log_gap[WAIT_B], 4);

        // Run 3: stalled writes with dense frames, reset mid-script (R11)
        @(negedge clk); rst_n = 1'b0; rand_ready = 1'b1; fp_width = 1; fp_period = 9;
        @(negedge clk); rst_n = 1'b1;
        repeat (70) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #2;
        check(!wr_valid && !done, "R11 mid-script reset", {wr_valid, done}, 0);
        clear_log();
        @(negedge clk); rst_n = 1'b1;
        wait_done();
        check(done == 1'b1, "R11 completes after restart", done, 1);
        check_log("run3");
        finish_run();
    end
endmodule